// File: doc/BRIEF.md
# Load/Store Execution Unit

This unit carries out the memory-class instructions of a small 32-bit load/store processor. The decoder hands it an instruction word marked valid. The unit names the two registers it needs: the base register and the data register. It then adds a sign-extended 20-bit offset to the base value to form a byte address, and presents that address as a word index.

The sign of the byte address picks the target. A non-negative address goes to data memory, and a negative address goes to a separate memory-mapped I/O port. A single instruction bit chooses between a load and a store. The sign of the address plays no part in that choice.

A store drives the data register's value onto the selected port with a write strobe. A load returns the read data, which arrives in the same cycle, for write-back into the data register. A load also latches the negative (N) and zero (Z) condition flags from that value.

Top module: `lsu_exec`

## Requirements
- R1: The byte address is `base_val` plus instruction bits 19:0 sign-extended from bit 19 to 32 bits.
- R2: `acc_word` equals byte address bits 31:2, so the two low address bits never reach either port.
- R3: Instruction bit 29 selects the operation, 0 for load and 1 for store, whatever the sign of the address.
- R4: For a valid instruction, a byte address with bit 31 clear strobes only the memory port (`mem_re`/`mem_we`), and one with bit 31 set strobes only the I/O port (`io_re`/`io_we`).
- R5: A valid store raises the write strobe of the selected port, puts `src_val` on `mem_wdata` and `io_wdata`, keeps both read strobes low, and keeps `wb_en` low.
- R6: A valid load raises the read strobe of the selected port and `wb_en`. It puts instruction bits 27:24 on `wb_dest`, and puts the selected port's read data on `wb_data` in the same cycle.
- R7: On the clock edge that ends a valid load, `flag_n` takes bit 31 of the loaded value, and `flag_z` is set exactly when the loaded value is zero.
- R8: A store, or a cycle with `ins_valid` low, leaves `flag_n` and `flag_z` unchanged.
- R9: With `ins_valid` low, no read or write strobe and no `wb_en` is asserted.
- R10: An active-low reset clears `flag_n` and `flag_z`.
- R11: `base_sel` always shows instruction bits 23:20, and `data_sel` always shows bits 27:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word is a valid memory-class instruction |
| ins_word | input | 32 | Decoded instruction word |
| base_sel | output | 4 | Register index of the base register |
| data_sel | output | 4 | Register index of the load destination or store source |
| base_val | input | 32 | Value of the base register |
| src_val | input | 32 | Value of the data register, used as store data |
| acc_word | output | 30 | Word index, shared by both ports |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 32 | Data memory write data |
| mem_rdata | input | 32 | Data memory read data, returned in the same cycle |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data, returned in the same cycle |
| wb_en | output | 1 | Write-back enable for a load |
| wb_dest | output | 4 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Address routing and the load/store choice are both settled in the same cycle, from different bits. That makes a negative-address store the case that exposes any mix-up between the two. The vector table pairs each operation with each address sign. It reaches a negative address through both a negative base and a negative offset, and it drives different read data on the two ports. A load from the wrong port, or a store redirected by the address sign, then shows up as a wrong strobe or a wrong write-back value. The flag update is also judged one edge later, after a store that follows a load, to confirm that the store left the flags as the load set them.

// File: rtl/lsu_exec.sv
module lsu_exec #(
  parameter int OFS_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ins_valid,
  input  logic [31:0] ins_word,
  output logic [3:0]  base_sel,
  output logic [3:0]  data_sel,
  input  logic [31:0] base_val,
  input  logic [31:0] src_val,
  output logic [29:0] acc_word,
  output logic        mem_re,
  output logic        mem_we,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        io_re,
  output logic        io_we,
  output logic [31:0] io_wdata,
  input  logic [31:0] io_rdata,
  output logic        wb_en,
  output logic [3:0]  wb_dest,
  output logic [31:0] wb_data,
  output logic        flag_n,
  output logic        flag_z
);
  localparam int EXT_W = 32 - OFS_W;
  localparam int ST_BIT = 29;

  logic [31:0] offset, byte_addr;
  logic        is_store, to_io, do_load;

  assign base_sel  = ins_word[23:20];
  assign data_sel  = ins_word[27:24];
  assign offset    = {{EXT_W{ins_word[OFS_W-1]}}, ins_word[OFS_W-1:0]};
  assign byte_addr = base_val + offset;
  assign acc_word  = byte_addr[31:2];
  assign is_store  = ins_word[ST_BIT];
  assign to_io     = byte_addr[31];
  assign do_load   = ins_valid && !is_store;

  assign mem_re    = do_load && !to_io;
  assign io_re     = do_load && to_io;
  assign mem_we    = ins_valid && is_store && !to_io;
  assign io_we     = ins_valid && is_store && to_io;
  assign mem_wdata = src_val;
  assign io_wdata  = src_val;

  assign wb_en     = do_load;
  assign wb_dest   = data_sel;
  assign wb_data   = to_io ? io_rdata : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (do_load) begin
      flag_n <= wb_data[31];
      flag_z <= (wb_data == 32'd0);
    end
  end
endmodule

// File: rtl/lsu_exec_chk.sv
module lsu_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_valid,
  input logic [31:0] ins_word,
  input logic [29:0] acc_word,
  input logic        mem_re,
  input logic        mem_we,
  input logic        io_re,
  input logic        io_we,
  input logic        wb_en,
  input logic [31:0] wb_data,
  input logic        flag_n,
  input logic        flag_z
);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> !(mem_re || mem_we || io_re || io_we || wb_en));

  p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !((mem_re || mem_we) && (io_re || io_we)));

  p_sign_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ((io_re || io_we) == acc_word[29]));

  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_word[29]) |-> ((mem_we || io_we) && !wb_en && !mem_re && !io_re));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_word[29]) |-> (wb_en && (mem_re || io_re) && !mem_we && !io_we));

  p_load_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_word[29]) |=> (flag_n == $past(wb_data[31]) && flag_z == ($past(wb_data) == 32'd0)));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && !ins_word[29]) |=> $stable({flag_n, flag_z}));
endmodule

bind lsu_exec lsu_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
  .acc_word(acc_word), .mem_re(mem_re), .mem_we(mem_we), .io_re(io_re),
  .io_we(io_we), .wb_en(wb_en), .wb_data(wb_data), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/tb_lsu_exec.sv
`timescale 1ns/1ps
module tb_lsu_exec;
  logic        clk = 1'b0, rst_n = 1'b0, ins_valid = 1'b0;
  logic [31:0] ins_word = '0, base_val = '0, src_val = '0, mem_rdata = '0, io_rdata = '0;
  logic [3:0]  base_sel, data_sel, wb_dest;
  logic [29:0] acc_word;
  logic        mem_re, mem_we, io_re, io_we, wb_en, flag_n, flag_z;
  logic [31:0] mem_wdata, io_wdata, wb_data;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_exec dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .base_sel(base_sel), .data_sel(data_sel), .base_val(base_val), .src_val(src_val),
    .acc_word(acc_word), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .io_re(io_re), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .wb_en(wb_en), .wb_dest(wb_dest), .wb_data(wb_data),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct packed {
    logic [31:0] ins, base, src, mrd, ird;
    logic [29:0] idx;
    logic        io, st, n, z;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h81200010, 32'h00000100, 32'h0, 32'h12345678, 32'hAAAA5555, 30'h00000044, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h833FFFFC, 32'h00000200, 32'h0, 32'h80000001, 32'h11111111, 30'h0000007F, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h84500000, 32'h00000008, 32'h0, 32'h00000000, 32'h22222222, 30'h00000002, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hA6700024, 32'h00001000, 32'hCAFEF00D, 32'h0, 32'h0, 30'h00000409, 1'b0, 1'b1, 1'b0, 1'b1},
    '{32'h88900004, 32'hFFFFFFC0, 32'h0, 32'h33333333, 32'hFFFFFF00, 30'h3FFFFFF1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'hA21FFFE0, 32'h00000010, 32'h0BADBEEF, 32'h0, 32'h0, 30'h3FFFFFFC, 1'b1, 1'b1, 1'b1, 1'b0},
    '{32'h8007FFFF, 32'h00000001, 32'h0, 32'h7FFFFFFF, 32'h00000000, 30'h00020000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h85400000, 32'h80000000, 32'h0, 32'h44444444, 32'h00000000, 30'h20000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hA9A00000, 32'hFFFFFFFC, 32'h01020304, 32'h0, 32'h0, 30'h3FFFFFFF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{32'h81100002, 32'h00000003, 32'h0, 32'h00000001, 32'h80000000, 30'h00000001, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic en, ez;
    logic [31:0] expd;
    repeat (3) @(negedge clk);
    chk(flag_n == 1'b0 && flag_z == 1'b0, "R10 reset flags", {30'd0, flag_n, flag_z}, 32'd0);
    rst_n = 1'b1;
    en = 1'b0; ez = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ins_valid = 1'b1; ins_word = VEC[i].ins; base_val = VEC[i].base;
      src_val = VEC[i].src; mem_rdata = VEC[i].mrd; io_rdata = VEC[i].ird;
      #1;
      chk(acc_word == VEC[i].idx, "R1 R2 word index", {2'b0, acc_word}, {2'b0, VEC[i].idx});
      chk(base_sel == VEC[i].ins[23:20] && data_sel == VEC[i].ins[27:24], "R11 register selects",
          {24'd0, base_sel, data_sel}, {24'd0, VEC[i].ins[23:16]});
      chk({mem_re, mem_we, io_re, io_we} == {!VEC[i].io && !VEC[i].st, !VEC[i].io && VEC[i].st,
           VEC[i].io && !VEC[i].st, VEC[i].io && VEC[i].st}, "R3 R4 strobes",
          {28'd0, mem_re, mem_we, io_re, io_we},
          {28'd0, !VEC[i].io && !VEC[i].st, !VEC[i].io && VEC[i].st, VEC[i].io && !VEC[i].st, VEC[i].io && VEC[i].st});
      if (VEC[i].st) begin
        chk(!wb_en && mem_wdata == VEC[i].src && io_wdata == VEC[i].src, "R5 store data",
            wb_en ? 32'hFFFFFFFF : (VEC[i].io ? io_wdata : mem_wdata), VEC[i].src);
      end else begin
        expd = VEC[i].io ? VEC[i].ird : VEC[i].mrd;
        chk(wb_en && wb_dest == VEC[i].ins[27:24] && wb_data == expd, "R6 load write-back", wb_data, expd);
        en = VEC[i].n; ez = VEC[i].z;
      end
      @(negedge clk);
      chk(flag_n == en && flag_z == ez, VEC[i].st ? "R8 store keeps flags" : "R7 load flags",
          {30'd0, flag_n, flag_z}, {30'd0, en, ez});
    end

    @(negedge clk);
    ins_valid = 1'b0; ins_word = 32'h81000000; base_val = 32'h0; mem_rdata = 32'h0; io_rdata = 32'h0;
    #1;
    chk(!(mem_re || mem_we || io_re || io_we || wb_en), "R9 no strobes when invalid",
        {27'd0, mem_re, mem_we, io_re, io_we, wb_en}, 32'd0);
    @(negedge clk);
    chk(flag_n == en && flag_z == ez, "R8 invalid keeps flags", {30'd0, flag_n, flag_z}, {30'd0, en, ez});

    ins_valid = 1'b1; ins_word = 32'h80000000; base_val = 32'h0; mem_rdata = 32'h0;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(flag_z == 1'b1 && flag_n == 1'b0, "R7 zero load sets Z", {30'd0, flag_n, flag_z}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk(flag_n == 1'b0 && flag_z == 1'b0, "R10 reset clears flags", {30'd0, flag_n, flag_z}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule